// File: doc/BRIEF.md
# Self-Checking Carry-Select Adder with Derived Upper Lane

This block adds two N-bit operands and a carry-in with a single ripple chain. The chain always runs with a carry-in of zero. Every position in that chain is a self-checking full-adder cell that raises its own error flag. The cell judges only its own inputs and outputs, so a wrong carry coming from a lower position does not make a healthy upper cell look faulty.

The result for a carry-in of one is not produced by a second adder. A prefix-AND network derives it from the carry-in-0 sum bits. A sum bit in the carry-in-1 result flips only when every carry-in-0 sum bit below it is 1. The real carry-in then picks one of the two precomputed results through a multiplexer with two rails. Each bit is produced both true and complemented, and a bit whose two rails agree counts as a fault.

The sum, the carry-out, the per-cell error flags and the summary error flag are registered. They appear one clock after the operands are sampled. A synchronous active-high reset clears them.

Top module: `scsa_top`

## Requirements
- R1: One clock after operands `op_a`, `op_b` and `cin` are sampled, {`cout`, `sum`} equals `op_a + op_b + cin` as an (N+1)-bit unsigned value.
- R2: The carry-in-0 chain is built from one self-checking cell per bit. `bit_err[i]` is the registered flag of cell i, and it stays 0 for every operand pair when the cells are fault-free.
- R3: Bit 0 of the carry-in-1 result is the complement of bit 0 of the carry-in-0 sum. With both operands 0 and `cin`=1, `sum` is 1.
- R4: Above bit 0, a carry-in-1 sum bit equals the carry-in-0 sum bit XOR the AND of all lower carry-in-0 sum bits. Example: `op_a`=0x00FF, `op_b`=0, `cin`=1 gives `sum`=0x0100.
- R5: The carry-in-1 carry-out equals the carry-in-0 carry-out XOR the AND of all carry-in-0 sum bits. Example: `op_a`=0xFFFF, `op_b`=0, `cin`=1 gives `cout`=1 and `sum`=0.
- R6: `cin`=0 selects the carry-in-0 result and `cin`=1 selects the carry-in-1 result. For the same operands, the two outputs differ by exactly 1.
- R7: Each bit of the select multiplexer has a true rail and a complement rail. `err_any` is the registered OR of all cell flags and of every bit whose two rails agree. On a fault-free block it stays 0.
- R8: While `rst` is 1 at a rising edge, `sum`, `cout`, `bit_err` and `err_any` are all 0 after that edge.
- R9: All-ones operands with `cin`=1 give `sum` all ones and `cout`=1. With `cin`=0 they give `sum` all ones except bit 0 = 0, and `cout`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | N | First operand |
| op_b | input | N | Second operand |
| cin | input | 1 | Carry-in, selects the result lane |
| sum | output | N | Registered sum |
| cout | output | 1 | Registered carry-out |
| bit_err | output | N | Registered per-cell error flags of the carry-in-0 chain |
| err_any | output | 1 | Registered summary error (cell flags or rail agreement) |

## Verification
A fault in the carry-in-0 chain, in the prefix-AND network or in the lane select shows up as a wrong `sum` or `cout` in the very next cycle. A bad derived lane appears only when `cin` is 1, and only for operand pairs whose low carry-in-0 sum bits are all ones. The bench therefore sweeps every operand and carry-in of a 4-bit instance. It also drives ones-runs of chosen lengths into a 16-bit instance. On a fault-free block the error flags must stay low throughout, so a cell or rail checker that trips falsely is seen within one cycle of the offending operands.

// File: rtl/scsa_pkg.sv
package scsa_pkg;

  typedef enum logic {
    LANE_CIN0 = 1'b0,
    LANE_CIN1 = 1'b1
  } lane_sel_e;

  // Cell check: with all three inputs equal, sum and carry must agree.
  // Otherwise they must differ. eqt_n is low exactly when the inputs are equal.
  function automatic logic cell_fault(input logic s, input logic c, input logic eqt_n);
    logic agree;
    agree = ~(s ^ c);
    return ~(agree ^ eqt_n);
  endfunction

endpackage

// File: rtl/scsa_cell.sv
module scsa_cell
  import scsa_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co,
  output logic fault
);
  logic eqt_n;

  // Sum and carry are formed with no shared sub-terms.
  assign s     = x ^ y ^ ci;
  assign co    = (x & y) | (ci & (x | y));
  assign eqt_n = ~((~x & ~y & ~ci) | (x & y & ci));
  assign fault = cell_fault(s, co, eqt_n);
endmodule

// File: rtl/scsa_chain0.sv
module scsa_chain0 #(
  parameter int N = 16
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  output logic [N-1:0] s0,
  output logic         c0,
  output logic [N-1:0] cell_err
);
  logic [N:0] carry;

  assign carry[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_cell
    scsa_cell u_cell (
      .x    (a[i]),
      .y    (b[i]),
      .ci   (carry[i]),
      .s    (s0[i]),
      .co   (carry[i+1]),
      .fault(cell_err[i])
    );
  end

  assign c0 = carry[N];
endmodule

// File: rtl/scsa_lane1.sv
module scsa_lane1 #(
  parameter int N = 16
) (
  input  logic [N-1:0] s0,
  input  logic         c0,
  output logic [N-1:0] s1,
  output logic         c1
);
  // run[j] is 1 when every carry-in-0 sum bit below j is 1.
  logic [N-1:0] run;

  assign run[0] = 1'b1;
  for (genvar j = 1; j < N; j++) begin : g_run
    assign run[j] = run[j-1] & s0[j-1];
  end

  for (genvar j = 0; j < N; j++) begin : g_flip
    assign s1[j] = s0[j] ^ run[j];
  end

  // The carry and the all-ones run cannot both be 1, so XOR is enough.
  assign c1 = c0 ^ (run[N-1] & s0[N-1]);
endmodule

// File: rtl/scsa_railmux.sv
module scsa_railmux
  import scsa_pkg::*;
#(
  parameter int W = 17
) (
  input  lane_sel_e    sel,
  input  logic [W-1:0] d0,
  input  logic [W-1:0] d1,
  output logic [W-1:0] y_t,
  output logic         rail_bad
);
  logic [W-1:0] d0_n;
  logic [W-1:0] d1_n;
  logic [W-1:0] y_c;
  logic [W-1:0] agree;

  assign d0_n = ~d0;
  assign d1_n = ~d1;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      y_t[i] = (sel == LANE_CIN1) ? d1[i]   : d0[i];
      y_c[i] = (sel == LANE_CIN1) ? d1_n[i] : d0_n[i];
    end
    assign agree[i] = ~(y_t[i] ^ y_c[i]);
  end

  assign rail_bad = |agree;
endmodule

// File: rtl/scsa_top.sv
module scsa_top
  import scsa_pkg::*;
#(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] op_a,
  input  logic [N-1:0] op_b,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout,
  output logic [N-1:0] bit_err,
  output logic         err_any
);
  localparam int W = N + 1;

  logic [N-1:0] sum0;
  logic         cout0;
  logic [N-1:0] sum1;
  logic         cout1;
  logic [N-1:0] cell_err;
  logic [W-1:0] picked;
  logic         rail_bad;
  lane_sel_e    lane;

  assign lane = lane_sel_e'(cin);

  scsa_chain0 #(.N(N)) u_chain0 (
    .a       (op_a),
    .b       (op_b),
    .s0      (sum0),
    .c0      (cout0),
    .cell_err(cell_err)
  );

  scsa_lane1 #(.N(N)) u_lane1 (
    .s0(sum0),
    .c0(cout0),
    .s1(sum1),
    .c1(cout1)
  );

  scsa_railmux #(.W(W)) u_mux (
    .sel     (lane),
    .d0      ({cout0, sum0}),
    .d1      ({cout1, sum1}),
    .y_t     (picked),
    .rail_bad(rail_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sum     <= '0;
      cout    <= 1'b0;
      bit_err <= '0;
      err_any <= 1'b0;
    end else begin
      sum     <= picked[N-1:0];
      cout    <= picked[N];
      bit_err <= cell_err;
      err_any <= (|cell_err) | rail_bad;
    end
  end
endmodule

// File: rtl/scsa_checker.sv
module scsa_checker #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] op_a,
  input logic [N-1:0] op_b,
  input logic         cin,
  input logic [N-1:0] sum,
  input logic         cout,
  input logic [N-1:0] bit_err,
  input logic         err_any,
  input logic [N-1:0] s0,
  input logic         c0,
  input logic [N-1:0] s1,
  input logic         c1
);
  localparam int W = N + 1;

  assert_sum_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ({cout, sum} ==
      ({1'b0, $past(op_a)} + {1'b0, $past(op_b)} + W'($past(cin)))));

  assert_cells_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (bit_err == '0));

  // Covers R3, R4 and R5: the derived lane is the carry-in-0 lane plus one.
  assert_lane1_R4: assert property (@(posedge clk) disable iff (rst)
    ({c1, s1} == ({c0, s0} + W'(1))));

  assert_rails_R7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> !err_any);

  assert_reset_R8: assert property (@(posedge clk)
    $past(rst) |-> (sum == '0 && !cout && bit_err == '0 && !err_any));
endmodule

bind scsa_top scsa_checker #(.N(N)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .op_a   (op_a),
  .op_b   (op_b),
  .cin    (cin),
  .sum    (sum),
  .cout   (cout),
  .bit_err(bit_err),
  .err_any(err_any),
  .s0     (sum0),
  .c0     (cout0),
  .s1     (sum1),
  .c1     (cout1)
);

// File: tb/tb_scsa_top.sv
module tb_scsa_top;
  localparam int NB = 16;
  localparam int NS = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NB-1:0] a_b = '0, b_b = '0;
  logic          c_b = 1'b0;
  logic [NS-1:0] a_s = '0, b_s = '0;
  logic          c_s = 1'b0;
  logic [NB-1:0] sum_b, err_b;
  logic          cout_b, any_b;
  logic [NS-1:0] sum_s, err_s;
  logic          cout_s, any_s;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  scsa_top #(.N(NB)) dut (
    .clk(clk), .rst(rst), .op_a(a_b), .op_b(b_b), .cin(c_b),
    .sum(sum_b), .cout(cout_b), .bit_err(err_b), .err_any(any_b));

  scsa_top #(.N(NS)) dut4 (
    .clk(clk), .rst(rst), .op_a(a_s), .op_b(b_s), .cin(c_s),
    .sum(sum_s), .cout(cout_s), .bit_err(err_s), .err_any(any_s));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Drive both instances at a falling edge, then check at the next falling edge.
  task automatic apply(input logic [NB-1:0] a, input logic [NB-1:0] b, input logic c,
                       input logic [NS-1:0] as, input logic [NS-1:0] bs, input logic cs,
                       input string tag);
    logic [NB:0] eb;
    logic [NS:0] es;
    @(negedge clk);
    a_b = a; b_b = b; c_b = c;
    a_s = as; b_s = bs; c_s = cs;
    eb = {1'b0, a} + {1'b0, b} + (NB+1)'(c);
    es = {1'b0, as} + {1'b0, bs} + (NS+1)'(cs);
    @(negedge clk);
    chk({tag, " R1 wide"}, 32'({cout_b, sum_b}), 32'(eb));
    chk({tag, " R1 small"}, 32'({cout_s, sum_s}), 32'(es));
    chk("R2 flags", 32'({err_s, err_b}), 32'd0);
    chk("R7 err_any", 32'({any_s, any_b}), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset wide", 32'({any_b, err_b, cout_b, sum_b}), 32'd0);
    chk("R8 reset small", 32'({any_s, err_s, cout_s, sum_s}), 32'd0);
    rst = 1'b0;

    // R3: carry-in-1 low bit.
    apply(16'h0000, 16'h0000, 1'b1, 4'h0, 4'h0, 1'b1, "R3");
    // R4: runs of ones of several lengths under carry-in 1.
    for (int k = 1; k < NB; k++) begin
      apply(NB'((32'd1 << k) - 1), 16'h0000, 1'b1, 4'h1, 4'h2, 1'b1, "R4");
      chk("R4 flip", 32'(sum_b), 32'd1 << k);
    end
    // R5: carry-out from an all-ones carry-in-0 sum.
    apply(16'hFFFF, 16'h0000, 1'b1, 4'hF, 4'h0, 1'b1, "R5");
    chk("R5 cout", 32'(cout_b), 32'd1);
    // R9: all-ones operands, both carry-ins.
    apply(16'hFFFF, 16'hFFFF, 1'b1, 4'hF, 4'hF, 1'b1, "R9");
    chk("R9 ones cin1", 32'({cout_b, sum_b}), 32'h1FFFF);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 4'hF, 4'hF, 1'b0, "R9");
    chk("R9 ones cin0", 32'({cout_b, sum_b}), 32'h1FFFE);
    // R6: same operands, each lane.
    apply(16'h1234, 16'h0F0F, 1'b0, 4'h5, 4'hA, 1'b0, "R6 lane0");
    apply(16'h1234, 16'h0F0F, 1'b1, 4'h5, 4'hA, 1'b1, "R6 lane1");

    // Exhaustive small sweep, random wide operands alongside.
    for (int x = 0; x < (1 << NS); x++)
      for (int y = 0; y < (1 << NS); y++)
        for (int c = 0; c < 2; c++)
          apply(NB'($urandom), NB'($urandom), c[0], x[NS-1:0], y[NS-1:0], c[0], "R6 sweep");

    // R8: reset in mid-stream with nonzero operands.
    @(negedge clk);
    a_b = 16'hABCD; b_b = 16'h1111; c_b = 1'b1; a_s = 4'h9; b_s = 4'h9; c_s = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    chk("R8 mid reset wide", 32'({any_b, err_b, cout_b, sum_b}), 32'd0);
    chk("R8 mid reset small", 32'({any_s, err_s, cout_s, sum_s}), 32'd0);
    rst = 1'b0;
    apply(16'h8000, 16'h8000, 1'b1, 4'h8, 4'h8, 1'b1, "R1 top carry");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule